// File: doc/BRIEF.md
# Sequential Pattern Trigger with Post-Trigger Capture Window

This block watches a stream of wide logic samples and decides when a capture has triggered. It holds a small bank of trigger stages. Each stage owns a compare mask, a compare value and a one-bit start flag. After an arm pulse, the stages are tried strictly one after another. A sample that satisfies the current stage moves the pointer to the next stage. When the satisfied stage carries the start flag, the block raises a one-cycle trigger pulse. It then keeps the capture enable high for a programmed number of further samples and finally signals that the capture is complete.

A controller programs the stages and the post-trigger length through a simple write port. It then pulses `arm`. The `capture_en` output gates whatever sample store sits downstream. `capture_done` tells the controller that the stored window is complete. A mask of zero on the first stage means "trigger at once". Such an arm fires the trigger on the very next cycle without waiting for a sample.

Top module: `trig_seq`

## Requirements
- R1: After reset, and until the first arm, `trig_pulse`, `capture_en` and `capture_done` are all 0, whatever samples arrive.
- R2: A stage is satisfied by a valid sample when every bit set in the stage mask equals the same bit of the stage value; bits with a clear mask bit are don't-care.
- R3: Only the stage under the pointer is compared. A sample that would satisfy a later stage while an earlier one is still pending has no effect.
- R4: Advancing one stage consumes the sample that caused it. One sample can never satisfy two stages, so the trigger comes no earlier than the sample after the previous stage's sample.
- R5: A satisfied stage whose start flag is set fires the trigger. The start flag is bit 3 of the config word. A satisfied stage without the flag only advances the pointer.
- R6: When the stage 0 mask is all zero at arm time, the trigger fires in the cycle after `arm`, regardless of the start flags.
- R7: `trig_pulse` is high for exactly one cycle per trigger, in the cycle after the firing sample (or after the arm for R6).
- R8: After the trigger, exactly 4×delay further valid samples are taken. In the cycle after the last of them, `capture_en` falls and `capture_done` rises. With delay 0, `capture_done` rises together with the trigger pulse and `capture_en` is 0. `capture_done` then holds until the next arm.
- R9: `capture_en` is high from the cycle after `arm` until capture completes, covering the pre-trigger samples.
- R10: An arm pulse in any state returns the stage pointer to stage 0, reloads the post-trigger counter and clears `capture_done`.
- R11: When the final stage is satisfied but has no start flag, the pointer stays there. No trigger fires, and `capture_en` stays high.
- R12: Samples presented with `smp_valid` low neither advance stages, fire the trigger nor count toward the post-trigger window.
- R13: Write encoding with the default parameters (5-bit address): bit 4 = 0 selects a stage register, with the stage in bits 3:2 and the field in bits 1:0 (0 mask, 1 value, 2 config). Field 3 is ignored. Address 0x10 is the post-trigger delay, and other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (5) | Configuration register address |
| cfg_wdata | input | DATA_W (32) | Configuration write data |
| arm | input | 1 | Start a new trigger hunt |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | DATA_W (32) | Sample word |
| trig_pulse | output | 1 | One-cycle trigger indication |
| capture_en | output | 1 | Sample store enable |
| capture_done | output | 1 | Capture window complete |

## Verification
The hardest situation to reach from the ports is a stage pointer that sits partway through the sequence and must be shown to have moved, stayed or been cleared. The pointer itself is not visible. The stimulus therefore uses samples that satisfy several stages at once, or only a later stage, and infers the pointer position from when the trigger finally fires. The same approach proves that a re-arm in mid-sequence sends the pointer back to stage 0: a later-stage sample given right after the re-arm must fail to advance it.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HUNT = 2'd1,
    SQ_POST = 2'd2,
    SQ_DONE = 2'd3
  } sq_state_e;

  localparam logic [1:0] FLD_MASK  = 2'd0;
  localparam logic [1:0] FLD_VALUE = 2'd1;
  localparam logic [1:0] FLD_CFG   = 2'd2;

endpackage

// File: rtl/trig_stage_bank.sv
module trig_stage_bank #(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4,
  parameter int STAGE_AW   = 2,
  parameter int START_BIT  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [STAGE_AW-1:0]   wr_stage,
  input  logic [1:0]            wr_field,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [DATA_W-1:0]     smp_data,
  output logic [NUM_STAGES-1:0] hit_vec,
  output logic [NUM_STAGES-1:0] start_vec,
  output logic                  first_mask_zero
);
  import trig_seq_pkg::*;

  logic [DATA_W-1:0] mask_q  [NUM_STAGES];
  logic [DATA_W-1:0] value_q [NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic sel;
    assign sel = wr_en && (wr_stage == STAGE_AW'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[s]    <= '0;
        value_q[s]   <= '0;
        start_vec[s] <= 1'b0;
      end else if (sel) begin
        case (wr_field)
          FLD_MASK:  mask_q[s]    <= wr_data;
          FLD_VALUE: value_q[s]   <= wr_data;
          FLD_CFG:   start_vec[s] <= wr_data[START_BIT];
          default:   ;
        endcase
      end
    end

    // Masked compare: a set mask bit demands equality with the value bit.
    assign hit_vec[s] = ((smp_data ^ value_q[s]) & mask_q[s]) == '0;
  end

  assign first_mask_zero = (mask_q[0] == '0);

endmodule

// File: rtl/trig_post_cnt.sv
module trig_post_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last
);
  localparam int TOT_W = CNT_W + 2;

  logic [TOT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= {load_val, 2'b00};
    end else if (step && cnt_q != '0) begin
      cnt_q <= cnt_q - TOT_W'(1);
    end
  end

  assign last = (cnt_q == TOT_W'(1));

endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4,
  parameter int CNT_W      = 16,
  parameter int START_BIT  = 3,
  localparam int STAGE_AW  = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
  localparam int ADDR_W    = STAGE_AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              arm,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              trig_pulse,
  output logic              capture_en,
  output logic              capture_done
);
  import trig_seq_pkg::*;

  localparam logic [STAGE_AW-1:0] LAST_STAGE = STAGE_AW'(NUM_STAGES - 1);

  sq_state_e             state_q;
  logic [STAGE_AW-1:0]   ptr_q;
  logic                  trig_q;
  logic [CNT_W-1:0]      delay_q;
  logic [NUM_STAGES-1:0] hit_vec;
  logic [NUM_STAGES-1:0] start_vec;
  logic                  first_mask_zero;
  logic                  cnt_last;
  logic                  global_sel;
  logic                  stage_wr;
  logic                  delay_wr;
  logic                  stage_hit;
  logic                  fire;
  logic                  immediate;

  assign global_sel = cfg_addr[ADDR_W-1];
  assign stage_wr   = cfg_we && !global_sel;
  assign delay_wr   = cfg_we && global_sel && (cfg_addr[ADDR_W-2:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      delay_q <= '0;
    end else if (delay_wr) begin
      delay_q <= cfg_wdata[CNT_W-1:0];
    end
  end

  trig_stage_bank #(
    .DATA_W     (DATA_W),
    .NUM_STAGES (NUM_STAGES),
    .STAGE_AW   (STAGE_AW),
    .START_BIT  (START_BIT)
  ) u_bank (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (stage_wr),
    .wr_stage        (cfg_addr[ADDR_W-2 -: STAGE_AW]),
    .wr_field        (cfg_addr[1:0]),
    .wr_data         (cfg_wdata),
    .smp_data        (smp_data),
    .hit_vec         (hit_vec),
    .start_vec       (start_vec),
    .first_mask_zero (first_mask_zero)
  );

  assign stage_hit = (state_q == SQ_HUNT) && smp_valid && hit_vec[ptr_q];
  assign fire      = stage_hit && start_vec[ptr_q];
  assign immediate = arm && first_mask_zero;

  trig_post_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (arm || fire),
    .load_val (delay_q),
    .step     ((state_q == SQ_POST) && smp_valid),
    .last     (cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      ptr_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (arm) begin
        ptr_q <= '0;
        if (immediate) begin
          trig_q  <= 1'b1;
          state_q <= (delay_q == '0) ? SQ_DONE : SQ_POST;
        end else begin
          state_q <= SQ_HUNT;
        end
      end else begin
        case (state_q)
          SQ_HUNT: begin
            if (fire) begin
              trig_q  <= 1'b1;
              state_q <= (delay_q == '0) ? SQ_DONE : SQ_POST;
            end else if (stage_hit && ptr_q != LAST_STAGE) begin
              ptr_q <= ptr_q + STAGE_AW'(1);
            end
          end
          SQ_POST: begin
            if (smp_valid && cnt_last) state_q <= SQ_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign trig_pulse   = trig_q;
  assign capture_en   = (state_q == SQ_HUNT) || (state_q == SQ_POST);
  assign capture_done = (state_q == SQ_DONE);

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic trig_pulse,
  input logic capture_en,
  input logic capture_done
);
  logic armed_seen;

  always_ff @(posedge clk) begin
    if (rst) armed_seen <= 1'b0;
    else if (arm) armed_seen <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !armed_seen |-> (!trig_pulse && !capture_en && !capture_done)); // R1

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse && !arm) |=> !trig_pulse); // R7

  AST_FELL_TO_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(capture_en) |-> capture_done); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (capture_done && !arm) |=> capture_done); // R8

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!capture_done || trig_pulse)); // R10

endmodule

bind trig_seq trig_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .arm          (arm),
  .trig_pulse   (trig_pulse),
  .capture_en   (capture_en),
  .capture_done (capture_done)
);

// File: tb/trig_seq_test.sv
module trig_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        arm = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic        trig_pulse, capture_en, capture_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trig_seq uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .trig_pulse(trig_pulse),
    .capture_en(capture_en), .capture_done(capture_done)
  );

  // {valid, data, expected trig, expected capture_en, expected done}
  localparam logic [35:0] VEC [12] = '{
    {1'b1, 32'hAB00_0000, 3'b010},  // later stage only, pointer at 0 (R3)
    {1'b0, 32'h0000_0011, 3'b010},  // invalid sample ignored (R12)
    {1'b1, 32'h1234_5611, 3'b010},  // stage 0 satisfied (R2)
    {1'b1, 32'hAB00_5011, 3'b010},  // satisfies 1 and 2, only advances (R4)
    {1'b1, 32'h0000_4000, 3'b010},  // stage 2 nibble wrong
    {1'b1, 32'hFFFF_5FFF, 3'b110},  // stage 2 with start flag fires (R5)
    {1'b1, 32'h0000_0000, 3'b010},  // post sample 1, pulse gone (R7)
    {1'b0, 32'h0000_0000, 3'b010},  // invalid, not counted (R12)
    {1'b1, 32'h0000_0000, 3'b010},  // post sample 2
    {1'b1, 32'h0000_0000, 3'b010},  // post sample 3
    {1'b1, 32'h0000_0000, 3'b001},  // post sample 4 ends window (R8)
    {1'b1, 32'h0000_0011, 3'b001}   // done holds (R8)
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic outs(input string rq, input logic t, input logic c, input logic d);
    chk({rq, " trig"}, {31'd0, trig_pulse}, {31'd0, t});
    chk({rq, " capture_en"}, {31'd0, capture_en}, {31'd0, c});
    chk({rq, " done"}, {31'd0, capture_done}, {31'd0, d});
  endtask

  task automatic step(input logic a, input logic v, input logic [31:0] d);
    arm = a; smp_valid = v; smp_data = d;
    @(posedge clk); #1;
    arm = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    outs("R1 reset", 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 32'h0000_0011);
    outs("R1 unarmed sample", 1'b0, 1'b0, 1'b0);

    // R13: stage s field f at {0,s,f}; delay at 0x10
    wr(5'h00, 32'h0000_00FF); wr(5'h01, 32'h0000_0011); wr(5'h02, 32'h0);
    wr(5'h04, 32'hFF00_0000); wr(5'h05, 32'hAB00_0000); wr(5'h06, 32'h0);
    wr(5'h08, 32'h0000_F000); wr(5'h09, 32'h0000_5000); wr(5'h0A, 32'h0000_0008);
    wr(5'h10, 32'd1);
    wr(5'h03, 32'hFFFF_FFFF);  // R13 field 3 ignored
    wr(5'h14, 32'd9);          // R13 non-delay global address ignored

    step(1'b1, 1'b0, 32'h0);
    outs("R9 arm", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      step(1'b0, VEC[i][35], VEC[i][34:3]);
      outs($sformatf("table row %0d R2 R3 R4 R5 R7 R8 R9 R12 R13", i),
           VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R10: re-arm mid-sequence returns pointer to stage 0
    step(1'b1, 1'b0, 32'h0);
    outs("R10 rearm clears done", 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 32'h0000_0011);
    step(1'b1, 1'b0, 32'h0);
    step(1'b0, 1'b1, 32'hAB00_0000);
    step(1'b0, 1'b1, 32'h0000_5000);
    outs("R10 pointer back at 0", 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 32'h0000_0011);
    step(1'b0, 1'b1, 32'hAB00_0000);
    step(1'b0, 1'b1, 32'h0000_5000);
    outs("R10 full sequence fires", 1'b1, 1'b1, 1'b0);

    // R11: last stage without start flag holds
    wr(5'h0A, 32'h0);
    step(1'b1, 1'b0, 32'h0);
    step(1'b0, 1'b1, 32'h0000_0011);
    step(1'b0, 1'b1, 32'hAB00_0000);
    step(1'b0, 1'b1, 32'h0000_5000);
    outs("R11 last stage no start", 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 32'h0000_5000);
    outs("R11 still waiting", 1'b0, 1'b1, 1'b0);

    // R6: stage 0 mask zero triggers on arm; delay 2 -> 8 samples
    wr(5'h00, 32'h0);
    wr(5'h10, 32'd2);
    step(1'b1, 1'b0, 32'h0);
    outs("R6 immediate trigger", 1'b1, 1'b1, 1'b0);
    for (int k = 1; k <= 7; k++) step(1'b0, 1'b1, 32'h0);
    outs("R8 seven of eight", 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 32'h0);
    outs("R8 eighth sample ends", 1'b0, 1'b0, 1'b1);

    // R8: delay 0 completes with the trigger
    wr(5'h10, 32'd0);
    step(1'b1, 1'b0, 32'h0);
    outs("R8 delay zero", 1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 32'h0);
    outs("R7 delay zero pulse ends", 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule